// File: doc/BRIEF.md
# Byte-Aligning Instruction Prefetch Queue

This block holds up to sixteen bytes of prefetched instruction stream in four 32-bit rows. The bus side deposits a whole 32-bit word into the next free row. The decode side reads through an alignment network. That network takes the row under the read pointer and the row after it, and places the byte at the read pointer in the lowest output lane. It does this for every byte offset. A multi-byte immediate that crosses a row boundary, or that wraps from the last row back to the first, therefore comes out as one contiguous value.

Each cycle the consumer states how many bytes it wants to see (one, two or four). It gets a valid indication when that many bytes are present. It then retires between one and four bytes with a consume count. The lowest aligned byte is also driven on a separate opcode output. Occupancy is tracked in bytes. A small state machine with the states Q_EMPTY, Q_PARTIAL and Q_FULL drives the empty and full flags. Its transitions are EMPTY to PARTIAL on a write, PARTIAL to FULL when the count reaches sixteen, FULL to PARTIAL on a consume, PARTIAL to EMPTY when the last byte is consumed, and any state to EMPTY on flush. A flush discards the contents and returns both pointers to zero in one clock.

Top module: `pfq_align_top`

## Requirements
- R1: After reset, occupancy is 0, empty is 1, full is 0 and the stored rows hold zero. A flush sets occupancy to 0 and both pointers to 0 at the next clock edge, so the next word written is returned from read offset 0.
- R2: A write (wr_en high) is accepted only when at least 4 bytes are free (occupancy at most 12). Otherwise it is ignored: occupancy is unchanged and no stored byte changes.
- R3: Occupancy after a clock edge equals the old occupancy, plus 4 for an accepted write, minus the consume count for an accepted consume. Both may happen in the same cycle. Occupancy never exceeds 16.
- R4: empty is 1 exactly when occupancy is 0, and full is 1 exactly when occupancy is 16.
- R5: rd_size encodes the read width: 0 is one byte, 1 is two bytes, 2 and 3 are four bytes. rd_valid is high exactly when rd_req is high and occupancy is at least that width.
- R6: Byte lane i of the aligned value is the queue byte at (read pointer + i) mod 16. This covers values that straddle two rows and values that wrap from row 3 to row 0. Queue byte 4k+j is byte lane j (bits 8j+7..8j) of the k-th written word.
- R7: rd_data carries the aligned value with the lanes above the requested width forced to zero: bits 31..8 for size 0, bits 31..16 for size 1.
- R8: opcode_byte always equals aligned lane 0, whatever rd_size is.
- R9: A consume count of 0, of more than 4, or of more than the current occupancy has no effect: occupancy and read pointer stay unchanged.
- R10: A flush takes priority over a write or consume in the same cycle: neither of them takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard contents and zero both pointers |
| wr_en | input | 1 | Row write strobe |
| wr_data | input | 32 | Word from the bus side |
| rd_req | input | 1 | Read request |
| rd_size | input | 2 | Read width code (R5) |
| consume | input | 3 | Number of bytes to retire (1 to 4) |
| rd_data | output | 32 | Aligned, width-masked read value |
| opcode_byte | output | 8 | Lowest aligned byte |
| rd_valid | output | 1 | Requested width is present |
| occupancy | output | 5 | Bytes held, 0 to 16 |
| empty | output | 1 | Queue holds no bytes |
| full | output | 1 | Queue holds 16 bytes |

## Verification
The hardest case to reach from the ports is a four-byte read that wraps from the last row into the first. The read pointer must sit at offset 13 to 15, and both rows must hold known data. That requires many writes and odd-sized consumes to build up first. The stimulus drives a long pseudo-random mix of writes, consume counts 0 to 7, all size codes and occasional flushes. The read pointer therefore drifts through every offset and passes the wrap boundary many times. Directed phases come first: they fill the queue to full, write while full, and issue illegal counts and a flush together with a write.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_t;

    localparam int LANES = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    // width code to byte count: 0 -> 1, 1 -> 2, otherwise 4
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pfq_rows.sv
module pfq_rows #(
    parameter int ROWS = 4,
    parameter int RW = $clog2(ROWS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [RW-1:0]              wrow,
    input  logic [pfq_pkg::WORD_W-1:0] wdata,
    input  logic [RW-1:0]              rrow,
    output logic [pfq_pkg::WORD_W-1:0] cur_row,
    output logic [pfq_pkg::WORD_W-1:0] nxt_row
);
    logic [pfq_pkg::WORD_W-1:0] store [ROWS];
    logic [RW-1:0] rrow_next;

    genvar g;
    generate
        for (g = 0; g < ROWS; g++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    store[g] <= '0;
                else if (we && (wrow == RW'(g)))
                    store[g] <= wdata;
            end
        end
    endgenerate

    // second selector wraps from the last row to the first
    assign rrow_next = rrow + RW'(1);
    assign cur_row   = store[rrow];
    assign nxt_row   = store[rrow_next];
endmodule

// File: rtl/pfq_rotate.sv
module pfq_rotate (
    input  logic [pfq_pkg::WORD_W-1:0] cur_row,
    input  logic [pfq_pkg::WORD_W-1:0] nxt_row,
    input  logic [1:0]                 ofs,
    output logic [pfq_pkg::WORD_W-1:0] aligned
);
    import pfq_pkg::*;

    logic [WORD_W-1:0] drv [LANES];

    genvar o, j;
    generate
        for (o = 0; o < LANES; o++) begin : g_drv
            logic [WORD_W-1:0] mix;
            // lanes below the offset are taken from the following row
            for (j = 0; j < LANES; j++) begin : g_lane
                if (j < o) begin : g_nxt
                    assign mix[j*LANE_W +: LANE_W] = nxt_row[j*LANE_W +: LANE_W];
                end else begin : g_cur
                    assign mix[j*LANE_W +: LANE_W] = cur_row[j*LANE_W +: LANE_W];
                end
            end
            if (o == 0) begin : g_r0
                assign drv[o] = mix;
            end else begin : g_rn
                assign drv[o] = {mix[o*LANE_W-1:0], mix[WORD_W-1:o*LANE_W]};
            end
        end
    endgenerate

    assign aligned = drv[ofs];
endmodule

// File: rtl/pfq_track.sv
module pfq_track #(
    parameter int DEPTH = 16,
    parameter int PW = $clog2(DEPTH),
    parameter int OW = $clog2(DEPTH + 1),
    parameter int RW = PW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [2:0]    consume,
    output logic [PW-1:0] rd_ptr,
    output logic [RW-1:0] wr_row,
    output logic [OW-1:0] occ,
    output logic          wr_ok,
    output logic          empty,
    output logic          full
);
    import pfq_pkg::*;

    qstate_t state, state_nx;
    logic [OW-1:0] occ_nx;
    logic          cons_ok;

    assign wr_ok   = !flush && wr_en && ((OW'(DEPTH) - occ) >= OW'(LANES));
    assign cons_ok = !flush && (consume != 3'd0) && (consume <= 3'd4)
                     && (OW'(consume) <= occ);

    always_comb begin
        occ_nx = occ;
        if (flush)
            occ_nx = '0;
        else
            occ_nx = occ + (wr_ok ? OW'(LANES) : OW'(0)) - (cons_ok ? OW'(consume) : OW'(0));
        if (occ_nx == '0)
            state_nx = Q_EMPTY;
        else if (occ_nx == OW'(DEPTH))
            state_nx = Q_FULL;
        else
            state_nx = Q_PARTIAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= Q_EMPTY;
            occ    <= '0;
            rd_ptr <= '0;
            wr_row <= '0;
        end else begin
            state <= state_nx;
            occ   <= occ_nx;
            if (flush) begin
                rd_ptr <= '0;
                wr_row <= '0;
            end else begin
                if (cons_ok) rd_ptr <= rd_ptr + PW'(consume);
                if (wr_ok)   wr_row <= wr_row + RW'(1);
            end
        end
    end

    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state)
            Q_EMPTY:   empty = 1'b1;
            Q_PARTIAL: ;
            Q_FULL:    full = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/pfq_align_top.sv
module pfq_align_top #(
    parameter int ROWS = 4,
    localparam int DEPTH = ROWS * pfq_pkg::LANES,
    localparam int PW = $clog2(DEPTH),
    localparam int OW = $clog2(DEPTH + 1),
    localparam int RW = $clog2(ROWS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_req,
    input  logic [1:0]  rd_size,
    input  logic [2:0]  consume,
    output logic [31:0] rd_data,
    output logic [7:0]  opcode_byte,
    output logic        rd_valid,
    output logic [4:0]  occupancy,
    output logic        empty,
    output logic        full
);
    import pfq_pkg::*;

    logic [PW-1:0]     rd_ptr;
    logic [RW-1:0]     wr_row;
    logic [OW-1:0]     occ;
    logic              wr_ok;
    logic [WORD_W-1:0] cur_row, nxt_row, aligned;
    logic [2:0]        nbytes;

    pfq_track #(.DEPTH(DEPTH)) u_track (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
        .consume(consume), .rd_ptr(rd_ptr), .wr_row(wr_row), .occ(occ),
        .wr_ok(wr_ok), .empty(empty), .full(full)
    );

    pfq_rows #(.ROWS(ROWS)) u_rows (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .wrow(wr_row), .wdata(wr_data),
        .rrow(rd_ptr[PW-1:2]), .cur_row(cur_row), .nxt_row(nxt_row)
    );

    pfq_rotate u_rot (
        .cur_row(cur_row), .nxt_row(nxt_row), .ofs(rd_ptr[1:0]), .aligned(aligned)
    );

    assign nbytes      = size_bytes(rd_size);
    assign rd_valid    = rd_req && (occ >= OW'(nbytes));
    assign opcode_byte = aligned[7:0];
    assign occupancy   = 5'(occ);

    always_comb begin
        rd_data = aligned;
        case (rd_size)
            2'd0:    rd_data[31:8]  = '0;
            2'd1:    rd_data[31:16] = '0;
            default: ;
        endcase
    end
endmodule

// File: rtl/pfq_align_checker.sv
module pfq_align_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        flush,
    input logic        wr_en,
    input logic [2:0]  consume,
    input logic [31:0] rd_data,
    input logic [1:0]  rd_size,
    input logic [7:0]  opcode_byte,
    input logic        rd_valid,
    input logic [4:0]  occupancy,
    input logic        empty,
    input logic        full
);
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= 5'd16); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full)); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == 5'd0 && empty)); // R1
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !flush && consume == 3'd0) |=> full); // R2
    AST_VALID_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !empty); // R5
    AST_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size == 2'd0) |-> (rd_data[31:8] == 24'd0)); // R7
    AST_OPCODE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        opcode_byte == rd_data[7:0]); // R8
    AST_BAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !wr_en && consume > 3'd4) |=> $stable(occupancy)); // R9
endmodule

bind pfq_align_top pfq_align_checker u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .consume(consume),
    .rd_data(rd_data), .rd_size(rd_size), .opcode_byte(opcode_byte),
    .rd_valid(rd_valid), .occupancy(occupancy), .empty(empty), .full(full)
);

// File: tb/pfq_align_top_test.sv
module pfq_align_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0, wr_en = 1'b0, rd_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_size = '0;
    logic [2:0]  consume = '0;
    logic [31:0] rd_data;
    logic [7:0]  opcode_byte;
    logic        rd_valid, empty, full;
    logic [4:0]  occupancy;

    int checks = 0, errors = 0;
    bit done = 0;

    int mem [16];
    int m_rp = 0, m_occ = 0, m_wrow = 0;
    string occ_tag = "R3";

    always #2.5 clk = ~clk;

    pfq_align_top uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .rd_req(rd_req), .rd_size(rd_size), .consume(consume), .rd_data(rd_data),
        .opcode_byte(opcode_byte), .rd_valid(rd_valid), .occupancy(occupancy),
        .empty(empty), .full(full)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_outputs();
        int n;
        logic [31:0] al, ex;
        n = (rd_size == 2'd0) ? 1 : (rd_size == 2'd1) ? 2 : 4;
        for (int i = 0; i < 4; i++) al[i*8 +: 8] = 8'(mem[(m_rp + i) % 16]);
        ex = al;
        if (n == 1) ex[31:8] = '0;
        if (n == 2) ex[31:16] = '0;
        check({occ_tag, " occupancy"}, occupancy, m_occ);
        check("R4 empty", empty, m_occ == 0);
        check("R4 full", full, m_occ == 16);
        check("R5 rd_valid", rd_valid, rd_req && (m_occ >= n));
        check("R6 R7 rd_data", rd_data, ex);
        check("R8 opcode_byte", opcode_byte, al[7:0]);
    endtask

    // drive one cycle, compare, then advance the model at the edge
    task automatic step(input bit fl, input bit we, input logic [31:0] d,
                        input bit rq, input logic [1:0] sz, input logic [2:0] cn);
        bit wok, cok;
        @(negedge clk);
        flush = fl; wr_en = we; wr_data = d; rd_req = rq; rd_size = sz; consume = cn;
        #1;
        compare_outputs();
        wok = !fl && we && (16 - m_occ >= 4);
        cok = !fl && cn != 0 && cn <= 4 && int'(cn) <= m_occ;
        @(posedge clk);
        if (fl) begin
            m_occ = 0; m_rp = 0; m_wrow = 0;
            occ_tag = we ? "R10" : "R1";
        end else begin
            if (wok) begin
                for (int i = 0; i < 4; i++) mem[m_wrow*4 + i] = int'(d[i*8 +: 8]);
                m_wrow = (m_wrow + 1) % 4;
                m_occ += 4;
            end
            if (cok) begin
                m_rp = (m_rp + int'(cn)) % 16;
                m_occ -= int'(cn);
            end
            if (we && !wok) occ_tag = "R2";
            else if (cn != 0 && !cok) occ_tag = "R9";
            else occ_tag = "R3";
        end
    endtask

    initial begin
        logic [31:0] lf = 32'hACE1_2345;
        for (int i = 0; i < 16; i++) mem[i] = 0;
        #12;
        check("R1 reset occupancy", occupancy, 0);
        check("R1 reset empty", empty, 1);
        check("R1 reset full", full, 0);
        check("R1 reset data", rd_data, 0);
        @(negedge clk); rst_n = 1'b1;
        // fill to full, then write while full (R2)
        for (int i = 0; i < 5; i++) step(0, 1, 32'h1111_1111 * (i + 1) + 32'h0403_0201, 1, 2, 0);
        // illegal counts (R9), odd consumes to straddle rows (R6)
        step(0, 0, 0, 1, 2, 3'd5);
        step(0, 0, 0, 1, 2, 3'd3);
        step(0, 1, 32'hDEAD_BEEF, 1, 1, 3'd4);
        for (int i = 0; i < 6; i++) step(0, 1, 32'hC0DE_0000 + 32'(i), 1, 2, 3'd3);
        // flush with write (R10), then first write returns from offset 0 (R1)
        step(1, 1, 32'h5555_AAAA, 1, 2, 3'd2);
        step(0, 1, 32'h8765_4321, 1, 2, 0);
        step(0, 0, 0, 1, 0, 3'd7);
        // consume more than held (R9)
        step(0, 0, 0, 1, 2, 3'd4);
        step(0, 0, 0, 1, 2, 3'd1);
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[15:10] == 6'd0, lf[0] | lf[1], {lf[7:0], lf[31:8]} ^ 32'(k),
                 lf[7], lf[6:5], lf[4:2]);
        end
        step(0, 0, 0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule